// File: doc/BRIEF.md
# Bus-Paced SPI Clock Master Bridge

This block connects one node of a wired-AND serial bus to a host SPI port that runs as a slave. The bridge is the SPI clock master. It produces one SCK pulse for each data bit of a bus byte, at bus bit speed. Each bit seen on the bus is handed to the host as it arrives. In the same bit slot, the host's outgoing bit is placed on the bus. When the byte ends, the host's shift register therefore holds the byte that actually appeared on the bus, not the byte the host sent.

A single open-drain handshake line carries two meanings. The host pulls the line low to ask for a transmission, and the bridge then keeps it low. The bridge also pulls it low while a byte is passing, so the host knows when to service its SPI register. Bus bytes are 10 bit slots long: a start bit of 0, eight data bits sent least significant bit first, and a stop bit of 1. A separate block tells the bridge when the bus has reached end of message.

Top module: `spi_bus_bridge`

## Requirements
- R1: During reset and right after it, `sck` is 0, `ctrl_low` is 0 and `bus_tx` is 1 (the bus is left marking).
- R2: A falling edge on `ctrl_line` while the bridge is idle is a transmit request. The request passes a `SYNC_STAGES` synchroniser and an edge detector. `bus_tx` then drops for the start bit exactly `SYNC_STAGES + 1 + SOM_BITS*BIT_CYC` cycles after the host first pulls the line low, provided the bus stays at 1 during that wait.
- R3: For a local transmit, `ctrl_low` is 1 from the cycle the request is accepted until the middle of the eighth data bit. That is `8*BIT_CYC + BIT_CYC/2` cycles after the first start-bit cycle, where it returns to 0.
- R4: For a byte started by another node, `ctrl_low` rises exactly `BIT_CYC` cycles after the first low cycle of that byte's start bit. It falls `8*BIT_CYC + BIT_CYC/2` cycles after that same low cycle.
- R5: Each data bit gives exactly one SCK pulse, with SPI mode CPOL=0, CPHA=1. SCK rises at the start of the bit slot and falls just after the middle of the slot. A byte gives exactly 8 pulses, and no pulses occur outside data bits.
- R6: The first bit the host shifts out (its MSB) goes out as bus data bit 0. The bus byte is therefore the bit reversal of the host byte.
- R7: The host receives the bus level sampled at mid-bit. Its first received bit is bus data bit 0, so after 8 pulses the host holds the bit reversal of the byte seen on the bus. This includes bits forced to 0 by another node.
- R8: If the host makes a new request during a local byte, after `ctrl_low` has released, the next start bit begins in the cycle right after the current stop bit ends. There is no start-of-message delay, and `ctrl_low` stays 1 across the boundary.
- R9: A stop bit sampled as 0 is a framing error. The bridge then makes no SCK pulses and ignores further bytes until `bus_idle` is seen high. After that it works normally again.
- R10: A request made after another node's start bit has been detected is ignored. `bus_tx` stays 1 for that byte and afterwards, and `ctrl_low` is 0 once the byte ends.
- R11: If the bus drops to 0 during the start-of-message wait, the local request is abandoned. The byte is received instead and `bus_tx` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; `BIT_CYC` cycles per bus bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_tx | input | 1 | Host SPI slave data output |
| ctrl_line | input | 1 | Level of the shared handshake line (low = asserted by anyone) |
| bus_rx | input | 1 | Received bus bit, already synchronous to `clk` |
| bus_idle | input | 1 | End-of-message indication from the idle detector |
| sck | output | 1 | SPI clock to the host, CPOL=0 CPHA=1 |
| host_rx | output | 1 | Data to the host SPI slave input |
| ctrl_low | output | 1 | 1 = bridge pulls the handshake line low |
| bus_tx | output | 1 | Bit to the bus driver (0 = dominant) |

## Verification
The assertions take several things for granted. `bus_rx` is assumed already synchronous, changing at most at each clock and held for whole bit slots by any sender. `host_tx` is assumed to change only in response to SCK rising edges, and `bus_idle` is assumed to rise only after a quiet bus. The stimulus keeps to these rules. The model of the other node drives the bus on falling clock edges and holds each bit for exactly `BIT_CYC` cycles. The host model updates its data bit only on SCK rising edges and samples only on SCK falling edges. End of message is given as a one-cycle pulse, and only after the bus has returned to 1.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SOM   = 2'd1,
    ST_FRAME = 2'd2,
    ST_HALT  = 2'd3
  } sbr_state_e;

  localparam int unsigned IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_START = 4'd0;
  localparam logic [IDX_W-1:0] IDX_D_LO  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_D_HI  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_STOP  = 4'd9;
endpackage

// File: rtl/sbr_line_sync.sv
module sbr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fell_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], line_i};
  end

  assign fell_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/sbr_bit_timer.sv
module sbr_bit_timer import sbr_pkg::*; #(
  parameter int BIT_CYC = 16,
  localparam int PH_W = $clog2(BIT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             load_ph1_i,
  output logic [PH_W-1:0]  ph_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             frame_end_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_o  <= '0;
      idx_o <= IDX_START;
    end else if (load_i) begin
      ph_o  <= load_ph1_i ? PH_W'(1) : '0;
      idx_o <= IDX_START;
    end else if (run_i) begin
      if (ph_o == PH_LAST) begin
        ph_o  <= '0;
        idx_o <= (idx_o == IDX_STOP) ? IDX_START : idx_o + 1'b1;
      end else begin
        ph_o <= ph_o + 1'b1;
      end
    end
  end

  assign frame_end_o = run_i && (ph_o == PH_LAST) && (idx_o == IDX_STOP);

  // R5: slot index never leaves the ten-slot frame
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_o <= IDX_STOP);
endmodule

// File: rtl/spi_bus_bridge.sv
module spi_bus_bridge import sbr_pkg::*; #(
  parameter int BIT_CYC     = 16,
  parameter int SOM_BITS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_tx,
  input  logic ctrl_line,
  input  logic bus_rx,
  input  logic bus_idle,
  output logic sck,
  output logic host_rx,
  output logic ctrl_low,
  output logic bus_tx
);
  localparam int PH_W    = $clog2(BIT_CYC);
  localparam int SOM_CYC = SOM_BITS * BIT_CYC;
  localparam int SOM_W   = $clog2(SOM_CYC + 1);
  localparam logic [PH_W-1:0]  PH_DRV   = PH_W'(1);
  localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(BIT_CYC / 2);
  localparam logic [PH_W-1:0]  PH_SAMP  = PH_W'(BIT_CYC / 2 - 1);
  localparam logic [SOM_W-1:0] SOM_LAST = SOM_W'(SOM_CYC - 1);

  sbr_state_e       state_q;
  logic             local_q, req_q;
  logic [SOM_W-1:0] som_cnt_q;
  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] idx;
  logic             frame_end, line_fell, req_fire, chain;
  logic             in_data, som_done, t_load, t_load_ph1;

  sbr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(ctrl_line), .fell_o(line_fell)
  );

  assign som_done = (state_q == ST_SOM) && (som_cnt_q == SOM_LAST);
  assign t_load = ((state_q == ST_IDLE) && !bus_rx)
               || ((state_q == ST_SOM) && (!bus_rx || som_done))
               || ((state_q == ST_FRAME) && frame_end && chain);
  assign t_load_ph1 = (state_q != ST_FRAME) && !bus_rx;

  sbr_bit_timer #(.BIT_CYC(BIT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_FRAME),
    .load_i(t_load), .load_ph1_i(t_load_ph1),
    .ph_o(ph), .idx_o(idx), .frame_end_o(frame_end)
  );

  assign in_data  = (idx >= IDX_D_LO) && (idx <= IDX_D_HI);
  assign req_fire = line_fell && !ctrl_low;
  assign chain    = req_q || (local_q && req_fire);

  assign sck = (state_q == ST_FRAME) && in_data && (ph <= PH_HALF);
  assign ctrl_low = req_q || ((state_q == ST_FRAME) &&
                    ((local_q && idx == IDX_START) ||
                     (in_data && !(idx == IDX_D_HI && ph >= PH_HALF))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      local_q   <= 1'b0;
      req_q     <= 1'b0;
      som_cnt_q <= '0;
      bus_tx    <= 1'b1;
      host_rx   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!bus_rx) begin
            state_q <= ST_FRAME;
            local_q <= 1'b0;
          end else if (req_fire) begin
            state_q   <= ST_SOM;
            req_q     <= 1'b1;
            som_cnt_q <= '0;
          end
        end
        ST_SOM: begin
          if (!bus_rx) begin
            state_q <= ST_FRAME;
            local_q <= 1'b0;
            req_q   <= 1'b0;
          end else if (som_done) begin
            state_q <= ST_FRAME;
            local_q <= 1'b1;
            req_q   <= 1'b0;
            bus_tx  <= 1'b0;
          end else begin
            som_cnt_q <= som_cnt_q + 1'b1;
          end
        end
        ST_FRAME: begin
          if (ph == PH_DRV && idx != IDX_START)
            bus_tx <= (idx == IDX_STOP) ? 1'b1 : (local_q ? host_tx : 1'b1);
          if (ph == PH_SAMP && in_data)
            host_rx <= bus_rx;
          if (ph == PH_SAMP && idx == IDX_STOP && !bus_rx) begin
            state_q <= ST_HALT;
            bus_tx  <= 1'b1;
            req_q   <= 1'b0;
          end else if (frame_end) begin
            if (chain) begin
              local_q <= 1'b1;
              bus_tx  <= 1'b0;
              req_q   <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (local_q && req_fire) begin
            req_q <= 1'b1;
          end
        end
        default: begin
          if (bus_idle) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R3 / R4: once inside a byte, the handshake releases only at mid data bit 8
  a_r3_ctrl_mid_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_low) && state_q == ST_FRAME && $past(state_q) == ST_FRAME)
      |-> (idx == IDX_D_HI && ph == PH_HALF));
  // R5: SCK rises only at the first cycle of a data slot
  a_r5_sck_rise_slot_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> (ph == '0 && idx >= IDX_D_LO));
  // R7: data to the host is steady across the sampling edge
  a_r7_rx_steady_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> $stable(host_rx));
  // R1: bus is left marking whenever no byte is in progress
  a_r1_mark_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FRAME) |-> bus_tx);
  // R9: after a framing error, only end of message releases the bridge
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !bus_idle) |=> (state_q == ST_HALT));
  // R10: a byte owned by another node never carries local data
  a_r10_no_drive_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRAME && !local_q) |-> bus_tx);
endmodule

// File: tb/spi_bus_bridge_tb.sv
module spi_bus_bridge_tb;
  localparam int BC  = 16;
  localparam int SOM = 2 * BC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_tx = 1'b1, host_pull = 1'b0, other_tx = 1'b1, bus_idle = 1'b0;
  logic sck, host_rx, ctrl_low, bus_tx;
  wire  ctrl_line = ~(ctrl_low | host_pull);
  wire  bus_rx    = bus_tx & other_tx;

  spi_bus_bridge #(.BIT_CYC(BC), .SOM_BITS(2), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_tx(host_tx), .ctrl_line(ctrl_line),
    .bus_rx(bus_rx), .bus_idle(bus_idle), .sck(sck), .host_rx(host_rx),
    .ctrl_low(ctrl_low), .bus_tx(bus_tx)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  // host SPI slave model
  logic [7:0] h_tx_sr = 8'hFF, h_rx_sr = 8'h00;
  int h_bits = 0, sck_rises = 0;
  always @(posedge sck) begin
    host_tx = h_tx_sr[7];
    h_tx_sr = {h_tx_sr[6:0], 1'b1};
    sck_rises++;
  end
  always @(negedge sck) begin
    h_rx_sr = {h_rx_sr[6:0], host_rx};
    h_bits++;
    if (h_bits == 8) begin
      h_bits = 0;
      if (exp_q.size() == 0) chk("R7 unexpected byte", h_rx_sr, 0);
      else chk({tag_q.pop_front(), " host byte"}, h_rx_sr, exp_q.pop_front());
    end
  end

  task automatic push(logic [7:0] b, string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  int other_start = 0;
  task automatic other_send(logic [7:0] b, logic stop_v);
    @(negedge clk);
    other_start = cyc;
    other_tx = 1'b0;
    repeat (BC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      other_tx = b[i];
      repeat (BC) @(negedge clk);
    end
    other_tx = stop_v;
    repeat (BC) @(negedge clk);
    other_tx = 1'b1;
  endtask

  int req_at = 0;
  task automatic host_request();
    @(negedge clk);
    host_pull = 1'b1;
    req_at = cyc;
    for (int i = 0; i < 10 && !ctrl_low; i++) @(negedge clk);
    host_pull = 1'b0;
  endtask

  task automatic wait_start(output int n);
    while (bus_tx) @(negedge clk);
    n = cyc;
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n, m, r0, lo;
    logic [7:0] bb;
    repeat (3) @(negedge clk);
    chk("R1 sck in reset", sck, 0);
    chk("R1 ctrl in reset", ctrl_low, 0);
    chk("R1 bus_tx in reset", bus_tx, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sck after reset", sck, 0);
    chk("R1 bus_tx after reset", bus_tx, 1);

    // local transmit: R2 delay, R6 order, R3 handshake, R5 pulses, R7 reflection
    h_tx_sr = 8'hB4; push(8'hB4, "R7 clean");
    r0 = sck_rises;
    host_request();
    wait_start(n);
    chk("R2 request to start bit", n - req_at, 3 + SOM);
    for (int k = 1; k <= 7; k++) begin wait_cyc(n + 16*k + 8); bb[k-1] = bus_tx; end
    wait_cyc(n + 135); chk("R3 ctrl before mid bit8", ctrl_low, 1);
    wait_cyc(n + 136); chk("R3 ctrl at mid bit8", ctrl_low, 0); bb[7] = bus_tx;
    chk("R6 bus byte", bb, rev8(8'hB4));
    wait_cyc(n + 170);
    chk("R5 pulses per byte", sck_rises - r0, 8);

    // R7: another node forces bus data bit 2 low
    h_tx_sr = 8'hF0; push(8'hD0, "R7 collided");
    host_request();
    wait_start(n);
    wait_cyc(n + 52); other_tx = 1'b0;
    wait_cyc(n + 59); other_tx = 1'b1;
    wait_cyc(n + 170);

    // R8: back-to-back local bytes
    h_tx_sr = 8'h11; push(8'h11, "R8 first"); push(8'h3C, "R8 second");
    host_request();
    wait_start(n);
    wait_cyc(n + 140);
    h_tx_sr = 8'h3C;
    host_request();
    wait_cyc(n + 159);
    chk("R8 stop bit still high", bus_tx, 1);
    chk("R8 ctrl held at boundary", ctrl_low, 1);
    wait_cyc(n + 160);
    chk("R8 next start immediate", bus_tx, 0);
    wait_cyc(n + 340);

    // R4: byte from another node
    push(rev8(8'hC5), "R4 foreign");
    fork
      other_send(8'hC5, 1'b1);
      begin
        @(negedge clk); m = other_start;
        wait_cyc(m + 15); chk("R4 ctrl before bit1", ctrl_low, 0);
        wait_cyc(m + 16); chk("R4 ctrl at bit1", ctrl_low, 1);
        wait_cyc(m + 135); chk("R4 ctrl before mid bit8", ctrl_low, 1);
        wait_cyc(m + 136); chk("R4 ctrl at mid bit8", ctrl_low, 0);
      end
    join
    repeat (5) @(negedge clk);

    // R10: request after a foreign start bit
    push(rev8(8'h3A), "R10 foreign");
    lo = 1;
    fork
      other_send(8'h3A, 1'b1);
      begin
        @(negedge clk); m = other_start;
        wait_cyc(m + 4);  host_pull = 1'b1;
        wait_cyc(m + 10); host_pull = 1'b0;
        while (cyc < m + 160 + 3*BC) begin lo &= bus_tx; @(negedge clk); end
      end
    join
    chk("R10 bus_tx never driven", lo, 1);
    chk("R10 ctrl released", ctrl_low, 0);

    // R11: foreign start during the start-of-message wait
    h_tx_sr = 8'h00; push(rev8(8'h96), "R11 foreign");
    host_request();
    repeat (10) @(negedge clk);
    lo = 1;
    fork
      other_send(8'h96, 1'b1);
      while (cyc < req_at + 220) begin lo &= bus_tx; @(negedge clk); end
    join
    chk("R11 local byte abandoned", lo, 1);
    repeat (5) @(negedge clk);

    // R9: framing error, lockout until end of message
    push(rev8(8'h5B), "R9 bad stop");
    other_send(8'h5B, 1'b0);
    repeat (3) @(negedge clk);
    r0 = sck_rises;
    other_send(8'h77, 1'b1);
    repeat (3) @(negedge clk);
    chk("R9 no pulses while halted", sck_rises - r0, 0);
    chk("R9 ctrl quiet while halted", ctrl_low, 0);
    bus_idle = 1'b1; @(negedge clk); bus_idle = 1'b0;
    repeat (3) @(negedge clk);
    push(rev8(8'h0F), "R9 after recovery");
    other_send(8'h0F, 1'b1);
    repeat (10) @(negedge clk);
    chk("R5 all expected bytes seen", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule